// File: doc/BRIEF.md
# Sequential Signed Shift-Add Multiplier

This block multiplies two 6-bit two's-complement numbers over several clock cycles instead of with a large combinational array. A one-cycle `start` request, taken only while the block is idle, latches both operands and the sign of the product, which is the XOR of the two operand sign bits. The block then works on magnitudes only. The multiplier register gets |a|, the multiplicand register gets |b| and the accumulator starts at zero, all three held at twice the operand width. A control state machine alternates a test-and-add step with a shift step. In the test-and-add step, the multiplicand is added to the accumulator when the multiplier's low bit is 1. In the shift step, the multiplier moves right one place and the multiplicand moves left one place.

After width-minus-one rounds the magnitude is complete. One exception applies: when `a` is the most negative value, its magnitude has its top bit set, so one more round is taken. A final step negates the accumulator (complement plus one) when the stored sign is negative. The same step records whether the true product fits the 6-bit signed range. The step after that raises `done` for one cycle. The low six bits of the accumulator appear on `product` and stay unchanged until the next accepted request.

Top module: `smul_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the following edge leaves `busy`, `done`, `ovf` and `product` all at 0.
- R2: A `start` sampled high while `busy` is 0 is accepted, and `busy` is 1 after that edge.
- R3: When `done` is 1, `product` equals the low 6 bits of the two's-complement product of the accepted `a` and `b`.
- R4: When `done` is 1, `ovf` is 1 exactly when the true signed product lies outside -32..31.
- R5: `done` is high for exactly one cycle, and after the next edge `busy` is 0.
- R6: `done` rises 13 clock edges after the accepting edge, counting that edge as the first. When the accepted `a` is -32 (bit pattern 100000), it rises after 15 edges.
- R7: A `start` while `busy` is 1 is ignored. The running operation keeps its operands and its timing, and it is not restarted.
- R8: While idle and `start` is low, `product` and `ovf` stay unchanged from the value left by the last `done`.
- R9: An operand of -32 is treated as magnitude 32. -32 x 1 gives product 100000 with `ovf` 0, -32 x -1 gives product 100000 with `ovf` 1, and 1 x -32 gives product 100000 with `ovf` 0.
- R10: A zero product with mixed operand signs (for example -5 x 0) gives product 0 and `ovf` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a multiplication; ignored while busy |
| a | input | 6 | Signed operand whose magnitude drives the multiplier register |
| b | input | 6 | Signed operand whose magnitude drives the multiplicand register |
| product | output | 6 | Low 6 bits of the signed product |
| ovf | output | 1 | Product does not fit the 6-bit signed range |
| busy | output | 1 | An operation is in progress (high through the done cycle) |
| done | output | 1 | One-cycle pulse marking a valid product and ovf |

## Verification
The most negative operand is tried on each side and against plus and minus one, along with the largest positive pairs and zero combined with negative values. These cases separate a correct magnitude path from one that loses the top bit of |-32|. They also show whether the overflow limits are asymmetric (32 allowed only for a negative result) and whether a negative zero is negated cleanly. Random signed pairs cover every mix of operand signs and low-bit patterns, so any wrong add condition or shift direction shows up in the product. Some runs inject a second request partway through an operation and then confirm that result, latency and held output still belong to the first request.

// File: rtl/smul_pkg.sv
package smul_pkg;

    // Default operand width of the multiplier.
    localparam int SMUL_W_DEF = 6;

    // Control sequence of the multiplier.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOAD  = 3'd1,
        ST_TEST  = 3'd2,
        ST_SHIFT = 3'd3,
        ST_NEG   = 3'd4,
        ST_DONE  = 3'd5
    } smul_state_e;

    // One-hot style strobes from control to datapath.
    typedef struct packed {
        logic capture;   // latch operands and product sign
        logic load;      // load magnitudes, clear accumulator
        logic test_add;  // add multiplicand if multiplier lsb set
        logic shift;     // multiplier right, multiplicand left
        logic negate;    // conditional negation and range check
    } smul_cmd_t;

    // Rounds needed to finish: one less than the operand width.
    function automatic int smul_rounds(input int w);
        return w - 1;
    endfunction

endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl
    import smul_pkg::*;
#(
    parameter int W = SMUL_W_DEF
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      mplr_rest_zero,
    output smul_cmd_t cmd,
    output logic      busy,
    output logic      done
);

    localparam int ROUNDS = smul_rounds(W);
    localparam int CNT_W  = $clog2(W + 2);

    smul_state_e      state_q, state_d;
    logic [CNT_W-1:0] round_q;
    logic             last_round;

    // Current shift completes the required rounds.
    assign last_round = (int'(round_q) >= ROUNDS - 1);

    always_comb begin
        cmd     = '0;
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    cmd.capture = 1'b1;
                    state_d     = ST_LOAD;
                end
            end
            ST_LOAD: begin
                cmd.load = 1'b1;
                state_d  = ST_TEST;
            end
            ST_TEST: begin
                cmd.test_add = 1'b1;
                state_d      = ST_SHIFT;
            end
            ST_SHIFT: begin
                cmd.shift = 1'b1;
                if (last_round && mplr_rest_zero) begin
                    state_d = ST_NEG;
                end else begin
                    state_d = ST_TEST;
                end
            end
            ST_NEG: begin
                cmd.negate = 1'b1;
                state_d    = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            round_q <= '0;
        end else begin
            state_q <= state_d;
            if (cmd.load) begin
                round_q <= '0;
            end else if (cmd.shift) begin
                round_q <= round_q + 1'b1;
            end
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = (state_q == ST_DONE);

endmodule

// File: rtl/smul_dp.sv
module smul_dp
    import smul_pkg::*;
#(
    parameter int W = SMUL_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  smul_cmd_t    cmd,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         mplr_rest_zero,
    output logic [W-1:0] product,
    output logic         ovf
);

    localparam int DW = 2 * W;
    localparam logic [DW-1:0] LIM_POS = DW'((1 << (W - 1)) - 1);
    localparam logic [DW-1:0] LIM_NEG = DW'(1 << (W - 1));

    logic [W-1:0]  opa_q, opb_q;
    logic          neg_q;
    logic [DW-1:0] mplr_q, mcnd_q, acc_q;
    logic          ovf_q;

    // Magnitude of a signed operand, widened so the most negative value fits.
    function automatic logic [DW-1:0] mag_of(input logic [W-1:0] v);
        logic [DW-1:0] ext;
        ext = {{W{v[W-1]}}, v};
        return v[W-1] ? (~ext + 1'b1) : ext;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            opa_q  <= '0;
            opb_q  <= '0;
            neg_q  <= 1'b0;
            mplr_q <= '0;
            mcnd_q <= '0;
            acc_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (cmd.capture) begin
                opa_q <= a;
                opb_q <= b;
                neg_q <= a[W-1] ^ b[W-1];
            end
            if (cmd.load) begin
                mplr_q <= mag_of(opa_q);
                mcnd_q <= mag_of(opb_q);
                acc_q  <= '0;
            end
            if (cmd.test_add && mplr_q[0]) begin
                acc_q <= acc_q + mcnd_q;
            end
            if (cmd.shift) begin
                mplr_q <= mplr_q >> 1;
                mcnd_q <= mcnd_q << 1;
            end
            if (cmd.negate) begin
                acc_q <= neg_q ? (~acc_q + 1'b1) : acc_q;
                ovf_q <= neg_q ? (acc_q > LIM_NEG) : (acc_q > LIM_POS);
            end
        end
    end

    // Multiplier bits above the one about to be shifted out.
    assign mplr_rest_zero = (mplr_q[DW-1:1] == '0);
    assign product        = acc_q[W-1:0];
    assign ovf            = ovf_q;

endmodule

// File: rtl/smul_seq.sv
module smul_seq
    import smul_pkg::*;
#(
    parameter int W = SMUL_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] product,
    output logic         ovf,
    output logic         busy,
    output logic         done
);

    smul_cmd_t cmd;
    logic      mplr_rest_zero;

    smul_ctrl #(.W(W)) u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .start          (start),
        .mplr_rest_zero (mplr_rest_zero),
        .cmd            (cmd),
        .busy           (busy),
        .done           (done)
    );

    smul_dp #(.W(W)) u_dp (
        .clk            (clk),
        .rst            (rst),
        .cmd            (cmd),
        .a              (a),
        .b              (b),
        .mplr_rest_zero (mplr_rest_zero),
        .product        (product),
        .ovf            (ovf)
    );

endmodule

// File: rtl/smul_chk.sv
module smul_chk #(
    parameter int W = 6
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic [W-1:0] product,
    input logic         ovf,
    input logic         busy,
    input logic         done
);

    localparam int DW      = 2 * W;
    localparam int LAT_STD = 2 * (W - 1) + 3;
    localparam int LAT_MIN = LAT_STD + 2;

    logic [W-1:0]         ref_a, ref_b;
    logic [7:0]           lat;
    logic signed [DW-1:0] full;
    logic                 ovf_exp;
    logic [7:0]           lat_exp;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_a <= '0;
            ref_b <= '0;
            lat   <= '0;
        end else if (start && !busy) begin
            ref_a <= a;
            ref_b <= b;
            lat   <= 8'd1;
        end else if (busy) begin
            lat <= lat + 8'd1;
        end
    end

    assign full    = $signed({{W{ref_a[W-1]}}, ref_a}) * $signed({{W{ref_b[W-1]}}, ref_b});
    assign ovf_exp = !((full[DW-1:W-1] == '0) || (full[DW-1:W-1] == '1));
    assign lat_exp = (ref_a == {1'b1, {(W-1){1'b0}}}) ? 8'(LAT_MIN) : 8'(LAT_STD);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!busy && !done && !ovf && product == '0));

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R3
    product_value_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (product == full[W-1:0]));

    // R4
    ovf_value_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (ovf == ovf_exp));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R6
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat == lat_exp));

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(product) && $stable(ovf)));

endmodule

bind smul_seq smul_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .a       (a),
    .b       (b),
    .product (product),
    .ovf     (ovf),
    .busy    (busy),
    .done    (done)
);

// File: tb/tb_smul_seq.sv
module tb_smul_seq;

    localparam int W = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [W-1:0] product;
    logic         ovf;
    logic         busy;
    logic         done;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    smul_seq #(.W(W)) dut (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .a       (a),
        .b       (b),
        .product (product),
        .ovf     (ovf),
        .busy    (busy),
        .done    (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sval(input logic [W-1:0] v);
        return v[W-1] ? int'(v) - (1 << W) : int'(v);
    endfunction

    function automatic int exp_prod(input logic [W-1:0] x, input logic [W-1:0] y);
        return (sval(x) * sval(y)) & ((1 << W) - 1);
    endfunction

    function automatic int exp_ovf(input logic [W-1:0] x, input logic [W-1:0] y);
        int p;
        p = sval(x) * sval(y);
        return (p > (1 << (W - 1)) - 1 || p < -(1 << (W - 1))) ? 1 : 0;
    endfunction

    function automatic int exp_lat(input logic [W-1:0] x);
        return (x == {1'b1, {(W-1){1'b0}}}) ? 2 * (W - 1) + 5 : 2 * (W - 1) + 3;
    endfunction

    // One multiplication; optionally pokes a second start while busy.
    task automatic run_mul(input logic [W-1:0] x, input logic [W-1:0] y, input bit poke);
        int n;
        bit seen;
        logic [W-1:0] hold_p;
        logic hold_o;
        @(negedge clk);
        a = x;
        b = y;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        a = ~x;
        b = ~y;
        check(busy == 1'b1, "R2 busy after accepted start", busy, 1);
        n = 1;
        seen = 0;
        while (n < 40 && !seen) begin
            if (poke && n == 4) begin
                start = 1'b1;
                a = x + 6'd3;
                b = y ^ 6'b010101;
            end else begin
                start = 1'b0;
            end
            if (done) begin
                seen = 1;
            end else begin
                @(negedge clk);
                n++;
            end
        end
        start = 1'b0;
        check(seen, "R5 done seen", int'(seen), 1);
        if (seen) begin
            check(n == exp_lat(x), poke ? "R7 latency with poke" : "R6 latency", n, exp_lat(x));
            check(int'(product) == exp_prod(x, y), poke ? "R7 product with poke" : "R3 product",
                  int'(product), exp_prod(x, y));
            check(int'(ovf) == exp_ovf(x, y), "R4 overflow", int'(ovf), exp_ovf(x, y));
            hold_p = product;
            hold_o = ovf;
            @(negedge clk);
            check(!done && !busy, "R5 done one cycle then idle", {done, busy}, 0);
            repeat (2) @(negedge clk);
            check(product == hold_p && ovf == hold_o, "R8 output held while idle",
                  int'({ovf, product}), int'({hold_o, hold_p}));
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                check(1'b0, "watchdog", cyc, 150000);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h1234_5eed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(!busy && !done && !ovf && product == '0, "R1 reset state",
              int'({busy, done, ovf, product}), 0);

        // Directed corners
        run_mul(6'd3, 6'd5, 0);
        run_mul(6'b100000, 6'd1, 0);        // R9 -32 x 1
        run_mul(6'b100000, 6'b111111, 0);   // R9 -32 x -1
        run_mul(6'd1, 6'b100000, 0);        // R9 1 x -32
        run_mul(6'b100000, 6'b100000, 0);   // R9 -32 x -32
        run_mul(6'b111011, 6'd0, 0);        // R10 -5 x 0
        run_mul(6'd0, 6'b111011, 0);        // R10 0 x -5
        run_mul(6'd31, 6'd31, 0);
        run_mul(6'b111000, 6'd4, 0);        // -8 x 4 = -32 fits
        run_mul(6'd8, 6'd4, 0);             // 32 overflows
        run_mul(6'b111111, 6'b111111, 0);
        run_mul(6'd7, 6'd9, 1);             // R7 poke while busy
        run_mul(6'b100000, 6'd2, 1);        // R7 poke on long run

        // Random pairs
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] rx, ry;
            rx = W'($urandom);
            ry = W'($urandom);
            run_mul(rx, ry, ($urandom % 5) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule